// File: doc/BRIEF.md
# ISDN D-Channel Serial Port

This block carries the two D-channel bits of every 8 kHz frame between an on-chip 2-bit word and the serial transmit pin (`dx_out`, with output enable `dx_oe`) and the serial receive pin (`dr_in`). Everything runs on a single system clock. The bit-clock rising and falling edges arrive as one-cycle strobes. A frame-sync strobe, which coincides with a bit-clock rising strobe, marks bit-clock period 0 of each frame.

The block has two transfer modes, selected by `cont_mode`:

- **Slot mode** (`cont_mode`=0). The two bits move at bit-clock rate inside a time slot that starts `slot_off` shift bits after frame sync. Setting `fmt4` makes every shift bit last two bit-clock periods.
- **Free-running mode** (`cont_mode`=1). The block generates a 16 kHz D clock (`dclk_out`) that is locked to the bit clock, and shifts one bit in each direction per D-clock period.

In both modes:

- Transmit bits change on the rising edge of the active shift clock.
- Receive bits are sampled on its falling edge.
- Bits go out most-significant first.
- The received pair is delivered with a one-cycle valid strobe.

Top module: `dchan_port`

## Requirements
- R1: After reset, `dx_oe`, `rx_valid` and `dclk_out` are 0. No bit moves and `dx_oe` stays 0 until the first `frame_sync` that coincides with `bclk_rise`.
- R2: In slot mode with `fmt4`=0, `dx_oe` is 1 during bit-clock periods `slot_off` and `slot_off`+1 and 0 in all other periods. `dx_out` carries `tx_word[1]` in the first of these periods and `tx_word[0]` in the second. `dx_out` changes only at a `bclk_rise` strobe.
- R3: In slot mode with `fmt4`=0, `dr_in` is sampled at the `bclk_fall` strobe of the two slot periods. `rx_word` becomes {first sample, second sample}.
- R4: In slot mode with `fmt4`=1, shift bit j spans bit-clock periods 2j and 2j+1. `dx_oe` is 1 for periods 2·`slot_off` through 2·`slot_off`+3. `dx_out` changes at the `bclk_rise` that starts an even period. `dr_in` is sampled at the `bclk_rise` that starts the odd period of each slot bit.
- R5: In free-running mode with `en`=1:
  - `dclk_out` is 1 during the first and third quarters of the frame and 0 during the other two quarters.
  - `dx_out` carries `tx_word[1]` from period 0 and `tx_word[0]` from period `FRAME_BCLKS`/2.
  - `dr_in` is sampled at the falling D-clock edges, which occur at periods `FRAME_BCLKS`/4 and 3·`FRAME_BCLKS`/4.
  - `dx_oe` is 1 in every period.
- R6: A slot whose second shift bit falls past the end of the frame is ignored: no `dx_oe` and no `rx_valid`. A frame has `FRAME_BCLKS` shift bits, or `FRAME_BCLKS`/2 shift bits when `fmt4`=1.
- R7: `rx_valid` is a single-cycle pulse, issued exactly once per frame in which a complete bit pair was received.
- R8: While `en`=0, `dx_oe` is 0 from the next cycle on, `dclk_out` is 0, and no `rx_valid` is issued.
- R9: The frame counter wraps by itself after `FRAME_BCLKS` bit-clock periods, so frames without a sync behave like synced ones. A `frame_sync` restarts the count at period 0 from any position.
- R10: In slot mode, `dclk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | D port enable |
| cont_mode | input | 1 | 1 = free-running 16 kHz mode, 0 = slot mode |
| fmt4 | input | 1 | Half-rate shifting in slot mode |
| bclk_rise | input | 1 | Bit-clock rising-edge strobe |
| bclk_fall | input | 1 | Bit-clock falling-edge strobe |
| frame_sync | input | 1 | Frame start; taken only together with `bclk_rise` |
| slot_off | input | $clog2(FRAME_BCLKS) | Slot start in shift bits after frame sync |
| tx_word | input | 2 | D bits to send; bit 1 goes out first |
| dr_in | input | 1 | Serial D receive data |
| dx_out | output | 1 | Serial D transmit data |
| dx_oe | output | 1 | Drive enable for `dx_out`; the pin floats when 0 |
| dclk_out | output | 1 | Generated 16 kHz D clock |
| rx_word | output | 2 | Received D bits; bit 1 was received first |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
The bench places slots at offset 0, at the last legal offset, and one position past it, at both rates. This catches:
- an off-by-one in the range test, which would either drive the pin in a slot that should be ignored or silence the last legal slot;
- a half-rate build that samples on the wrong parity, which shows up as swapped or shifted receive bits, because the receive pattern differs in every period.

In free-running mode, the bench checks that the D-clock quarters and the sample points line up, so that a design dividing from the wrong count would misplace both. It also checks that frames without a sync after a partial frame wrap and re-sync correctly, and that nothing is driven before the first sync or while the port is disabled.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    typedef enum logic {
        XFER_SLOT = 1'b0,
        XFER_CONT = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic       dx;
        logic       sav;
        logic       rx_b1;
        logic [1:0] rx_word;
        logic       rx_valid;
    } shift_state_t;

endpackage

// File: rtl/dchan_timing.sv
module dchan_timing
    import dchan_pkg::*;
#(
    parameter  int FRAME_BCLKS = 32,
    localparam int CW          = $clog2(FRAME_BCLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cont_mode,
    input  logic          fmt4,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  logic          frame_sync,
    input  logic [CW-1:0] slot_off,
    output logic          tx_ev,
    output logic          tx_bit,
    output logic          rx_ev,
    output logic          rx_bit,
    output logic          oe,
    output logic          dclk
);
    localparam int HALF = FRAME_BCLKS / 2;
    localparam int QTR  = FRAME_BCLKS / 4;
    localparam int LAST = FRAME_BCLKS - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          synced;
        logic          oe;
        logic          dclk;
    } tstate_t;

    tstate_t    st_d, st_q;
    xfer_mode_e mode;
    logic          fs_ev, live, slot_ok;
    logic [CW-1:0] nxt;
    logic [CW:0]   sbits, off_w, sidx_n, sidx_c;
    logic          hit_n, hit_c, idx_n, idx_c;

    assign mode = xfer_mode_e'(cont_mode);

    always_comb begin
        st_d   = st_q;
        fs_ev  = frame_sync & bclk_rise;
        nxt    = fs_ev ? '0 : ((st_q.cnt == CW'(LAST)) ? '0 : st_q.cnt + 1'b1);
        sbits  = fmt4 ? (CW+1)'(HALF) : (CW+1)'(FRAME_BCLKS);
        off_w  = {1'b0, slot_off};
        slot_ok = (off_w + 1'b1) < sbits;
        sidx_n = fmt4 ? {2'b00, nxt[CW-1:1]} : {1'b0, nxt};
        sidx_c = {1'b0, st_q.cnt};
        hit_n  = slot_ok & ((sidx_n == off_w) | (sidx_n == off_w + 1'b1));
        hit_c  = slot_ok & ((sidx_c == off_w) | (sidx_c == off_w + 1'b1));
        idx_n  = (sidx_n != off_w);
        idx_c  = (sidx_c != off_w);
        live   = en & (st_q.synced | fs_ev);

        tx_ev  = 1'b0;
        tx_bit = 1'b0;
        rx_ev  = 1'b0;
        rx_bit = 1'b0;
        if (mode == XFER_CONT) begin
            if (bclk_rise && live) begin
                if (nxt == '0 || nxt == CW'(HALF)) begin
                    tx_ev  = 1'b1;
                    tx_bit = (nxt == CW'(HALF));
                end
                if (nxt == CW'(QTR) || nxt == CW'(3*QTR)) begin
                    rx_ev  = 1'b1;
                    rx_bit = (nxt == CW'(3*QTR));
                end
            end
        end else if (fmt4) begin
            if (bclk_rise && live && hit_n) begin
                tx_ev  = ~nxt[0];
                rx_ev  = nxt[0];
                tx_bit = idx_n;
                rx_bit = idx_n;
            end
        end else begin
            if (bclk_rise && live && hit_n) begin
                tx_ev  = 1'b1;
                tx_bit = idx_n;
            end
            if (bclk_fall && en && st_q.synced && hit_c) begin
                rx_ev  = 1'b1;
                rx_bit = idx_c;
            end
        end

        if (fs_ev) st_d.synced = 1'b1;
        if (bclk_rise) begin
            st_d.cnt = nxt;
            st_d.oe  = live & ((mode == XFER_CONT) | hit_n);
        end
        if (mode == XFER_CONT) begin
            if (tx_ev)      st_d.dclk = 1'b1;
            else if (rx_ev) st_d.dclk = 1'b0;
        end
        if (!en) st_d.oe = 1'b0;
        if (!en || mode != XFER_CONT) st_d.dclk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe   = st_q.oe;
    assign dclk = st_q.dclk;

    assert_dclk_rise_on_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dclk) |-> $past(tx_ev));
    assert_events_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall) |-> !(tx_ev && rx_ev));
    assert_oe_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.oe);
    assert_no_dclk_in_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode |=> !st_q.dclk);
endmodule

// File: rtl/dchan_shift.sv
module dchan_shift
    import dchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_ev,
    input  logic       tx_bit,
    input  logic       rx_ev,
    input  logic       rx_bit,
    input  logic [1:0] tx_word,
    input  logic       dr_in,
    output logic       dx,
    output logic [1:0] rx_word,
    output logic       rx_valid
);
    shift_state_t sh_d, sh_q;

    always_comb begin
        sh_d          = sh_q;
        sh_d.rx_valid = 1'b0;
        if (tx_ev) begin
            if (!tx_bit) begin
                sh_d.dx  = tx_word[1];
                sh_d.sav = tx_word[0];
            end else begin
                sh_d.dx  = sh_q.sav;
            end
        end
        if (rx_ev) begin
            if (!rx_bit) begin
                sh_d.rx_b1 = dr_in;
            end else begin
                sh_d.rx_word  = {sh_q.rx_b1, dr_in};
                sh_d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dx       = sh_q.dx;
    assign rx_word  = sh_q.rx_word;
    assign rx_valid = sh_q.rx_valid;

    assert_rx_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));
endmodule

// File: rtl/dchan_port.sv
module dchan_port
    import dchan_pkg::*;
#(
    parameter  int FRAME_BCLKS = 32,
    localparam int CW          = $clog2(FRAME_BCLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cont_mode,
    input  logic          fmt4,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  logic          frame_sync,
    input  logic [CW-1:0] slot_off,
    input  logic [1:0]    tx_word,
    input  logic          dr_in,
    output logic          dx_out,
    output logic          dx_oe,
    output logic          dclk_out,
    output logic [1:0]    rx_word,
    output logic          rx_valid
);
    logic tx_ev, tx_bit, rx_ev, rx_bit;

    dchan_timing #(.FRAME_BCLKS(FRAME_BCLKS)) timing_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cont_mode  (cont_mode),
        .fmt4       (fmt4),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .frame_sync (frame_sync),
        .slot_off   (slot_off),
        .tx_ev      (tx_ev),
        .tx_bit     (tx_bit),
        .rx_ev      (rx_ev),
        .rx_bit     (rx_bit),
        .oe         (dx_oe),
        .dclk       (dclk_out)
    );

    dchan_shift shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_ev    (tx_ev),
        .tx_bit   (tx_bit),
        .rx_ev    (rx_ev),
        .rx_bit   (rx_bit),
        .tx_word  (tx_word),
        .dr_in    (dr_in),
        .dx       (dx_out),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assert_dx_moves_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(dx_out));
    assert_rxv_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(en));
endmodule

// File: tb/dchan_port_tb.sv
module dchan_port_tb_top;
    localparam int FB = 32;
    localparam int CW = $clog2(FB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, cont_mode = 1'b0, fmt4 = 1'b0;
    logic bclk_rise = 1'b0, bclk_fall = 1'b0, frame_sync = 1'b0;
    logic [CW-1:0] slot_off = '0;
    logic [1:0] tx_word = 2'b00;
    logic dr_in = 1'b0;
    logic dx_out, dx_oe, dclk_out, rx_valid;
    logic [1:0] rx_word;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [FB-1:0] dr_plan;
    logic obs_oe [FB];
    logic obs_dx [FB];
    logic obs_dclk [FB];
    int rx_cnt;
    logic [1:0] rx_got;

    always #5 clk = ~clk;

    dchan_port #(.FRAME_BCLKS(FB)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cont_mode(cont_mode), .fmt4(fmt4),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .frame_sync(frame_sync),
        .slot_off(slot_off), .tx_word(tx_word), .dr_in(dr_in),
        .dx_out(dx_out), .dx_oe(dx_oe), .dclk_out(dclk_out),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic take_rx();
        if (rx_valid) begin
            rx_cnt++;
            rx_got = rx_word;
        end
    endtask

    task automatic do_period(input logic fsync, input int k);
        @(negedge clk);
        bclk_rise = 1'b1; frame_sync = fsync; dr_in = dr_plan[k];
        @(negedge clk);
        take_rx();
        bclk_rise = 1'b0; frame_sync = 1'b0;
        obs_oe[k] = dx_oe; obs_dx[k] = dx_out; obs_dclk[k] = dclk_out;
        @(negedge clk);
        take_rx();
        bclk_fall = 1'b1;
        @(negedge clk);
        take_rx();
        bclk_fall = 1'b0;
    endtask

    function automatic bit slot_valid();
        return fmt4 ? (int'(slot_off) + 1 < FB/2) : (int'(slot_off) + 1 < FB);
    endfunction

    function automatic bit exp_oe(input int k, input bit on);
        int s;
        if (!on || !en) return 1'b0;
        if (cont_mode) return 1'b1;
        if (!slot_valid()) return 1'b0;
        s = fmt4 ? k / 2 : k;
        return (s == int'(slot_off)) || (s == int'(slot_off) + 1);
    endfunction

    function automatic bit exp_dx(input int k);
        int s;
        if (cont_mode) return (k < FB/2) ? tx_word[1] : tx_word[0];
        s = fmt4 ? k / 2 : k;
        return (s == int'(slot_off)) ? tx_word[1] : tx_word[0];
    endfunction

    function automatic logic [1:0] exp_rx();
        int o = int'(slot_off);
        if (cont_mode) return {dr_plan[FB/4], dr_plan[3*FB/4]};
        if (fmt4) return {dr_plan[2*o+1], dr_plan[2*o+3]};
        return {dr_plan[o], dr_plan[o+1]};
    endfunction

    // runs nper periods; on = design is expected to be synced
    task automatic run_check(input logic fsync, input bit on, input int nper,
                             input logic [FB-1:0] seed, input string tag);
        bit eo, ed, want_rx;
        dr_plan = seed;
        rx_cnt = 0;
        rx_got = 2'b00;
        for (int k = 0; k < nper; k++) do_period((k == 0) ? fsync : 1'b0, k);
        for (int k = 0; k < nper; k++) begin
            eo = exp_oe(k, on);
            chk(obs_oe[k] == eo, tag, int'(obs_oe[k]), int'(eo), $sformatf("dx_oe period %0d", k));
            if (eo)
                chk(obs_dx[k] == exp_dx(k), tag, int'(obs_dx[k]), int'(exp_dx(k)),
                    $sformatf("dx_out period %0d", k));
            ed = on && en && cont_mode && ((k % (FB/2)) < FB/4);
            if (cont_mode)
                chk(obs_dclk[k] == ed, "R5", int'(obs_dclk[k]), int'(ed), $sformatf("dclk period %0d", k));
            else
                chk(obs_dclk[k] == 1'b0, "R10", int'(obs_dclk[k]), 0, $sformatf("dclk period %0d", k));
        end
        if (nper == FB) begin
            want_rx = on && en && (cont_mode || slot_valid());
            chk(rx_cnt == int'(want_rx), "R7", rx_cnt, int'(want_rx), {tag, " rx_valid count"});
            if (want_rx)
                chk(rx_got == exp_rx(), (cont_mode ? "R5" : (fmt4 ? "R4" : "R3")),
                    int'(rx_got), int'(exp_rx()), {tag, " rx_word"});
        end
    endtask

    task automatic setup(input logic e, input logic c, input logic f4, input int off, input logic [1:0] tw);
        en = e; cont_mode = c; fmt4 = f4; slot_off = CW'(off); tx_word = tw;
    endtask

    task automatic t_reset();
        chk(dx_oe == 1'b0, "R1", int'(dx_oe), 0, "dx_oe after reset");
        chk(rx_valid == 1'b0, "R1", int'(rx_valid), 0, "rx_valid after reset");
        chk(dclk_out == 1'b0, "R1", int'(dclk_out), 0, "dclk after reset");
        setup(1'b1, 1'b0, 1'b0, 2, 2'b10);
        run_check(1'b0, 1'b0, FB, 32'hFFFF_FFFF, "R1");
        setup(1'b1, 1'b1, 1'b0, 0, 2'b10);
        run_check(1'b0, 1'b0, FB, 32'hFFFF_FFFF, "R1");
    endtask

    task automatic t_slot_full();
        setup(1'b1, 1'b0, 1'b0, 5, 2'b10);
        run_check(1'b1, 1'b1, FB, 32'h0000_0020, "R2");
        setup(1'b1, 1'b0, 1'b0, 0, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hAAAA_AAA9, "R2");
        setup(1'b1, 1'b0, 1'b0, 30, 2'b01);
        run_check(1'b1, 1'b1, FB, 32'h4000_0000, "R3");
    endtask

    task automatic t_slot_half();
        setup(1'b1, 1'b0, 1'b1, 3, 2'b10);
        run_check(1'b1, 1'b1, FB, 32'h0000_0280, "R4");
        setup(1'b1, 1'b0, 1'b1, 14, 2'b01);
        run_check(1'b1, 1'b1, FB, 32'h5000_0000, "R4");
    endtask

    task automatic t_range();
        setup(1'b1, 1'b0, 1'b0, 31, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hFFFF_FFFF, "R6");
        setup(1'b1, 1'b0, 1'b1, 15, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hFFFF_FFFF, "R6");
        setup(1'b1, 1'b0, 1'b1, 20, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hFFFF_FFFF, "R6");
    endtask

    task automatic t_cont();
        setup(1'b1, 1'b1, 1'b0, 7, 2'b10);
        run_check(1'b1, 1'b1, FB, 32'h0000_0100, "R5");
        setup(1'b1, 1'b1, 1'b0, 7, 2'b01);
        run_check(1'b1, 1'b1, FB, 32'h0100_0000, "R5");
    endtask

    task automatic t_disable();
        setup(1'b0, 1'b1, 1'b0, 0, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hFFFF_FFFF, "R8");
        setup(1'b0, 1'b0, 1'b0, 4, 2'b11);
        run_check(1'b1, 1'b1, FB, 32'hFFFF_FFFF, "R8");
    endtask

    task automatic t_freerun();
        setup(1'b1, 1'b0, 1'b0, 9, 2'b10);
        run_check(1'b1, 1'b1, FB, 32'h0000_0200, "R9");
        setup(1'b1, 1'b0, 1'b0, 9, 2'b01);
        run_check(1'b0, 1'b1, FB, 32'h0000_0400, "R9");
        setup(1'b1, 1'b0, 1'b0, 5, 2'b10);
        run_check(1'b0, 1'b1, 10, 32'h0000_0000, "R9");
        setup(1'b1, 1'b0, 1'b0, 2, 2'b01);
        run_check(1'b1, 1'b1, FB, 32'h0000_0008, "R9");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slot_full();
        t_slot_half();
        t_range();
        t_cont();
        t_disable();
        t_freerun();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule